// File: doc/BRIEF.md
# ECC Error Address and Syndrome Logger

This block sits beside the SECDED check logic of a memory read path. When the decoder flags a corrected (single-bit) or an uncorrectable (multi-bit) error, the logger stores the upper bits of the failing physical address, the 8-bit syndrome and the error kind. All of this goes into one 32-bit status word that software reads and writes. Only the earliest error is kept. Later errors cannot overwrite it until software acknowledges the held one by writing a one to its status bit.

The same word carries three control bits. One suppresses the automatic scrub write-back that a corrected read would otherwise request. One lets a newly logged single-bit error raise a one-cycle interrupt pulse. One lets a newly logged multi-bit error raise a one-cycle bus-error pulse. The scrub request goes out for every corrected read, whether or not that read gets logged. It carries the full read address so that the write-back datapath can repair the location.

Top module: `ecc_err_logger`

## Requirements
- R1: After synchronous reset the status word reads 0x00000000, and the interrupt, bus-error and scrub outputs are low.
- R2: With no error held, a single-bit event sets bit 0. In the same cycle it loads bits 30:12 with address bits 31:13 and bits 11:4 with the syndrome.
- R3: With no error held, a multi-bit event sets bit 1 and loads the address and syndrome fields the same way.
- R4: A single-bit and a multi-bit event in the same cycle, with nothing held, log a multi-bit error: bit 1 is set and bit 0 stays 0.
- R5: While bit 0 or bit 1 is set, new events of either kind change no status bit and leave bits 30:4 frozen. At most one of bits 1:0 is ever set.
- R6: Writing 1 to bit 0 or bit 1 clears that bit, and writing 0 leaves it unchanged. Once both are clear, the next event is logged with fresh fields.
- R7: A write loads bit 31 (scrub disable), bit 3 (bus-error enable) and bit 2 (interrupt enable) from the write data. Write data in bits 30:4 is ignored.
- R8: `sbe_irq` is high for exactly the one cycle after a single-bit error is logged, and only if bit 2 was 1 before that edge.
- R9: `mbe_berr` is high for exactly the one cycle after a multi-bit error is logged, and only if bit 3 was 1 before that edge.
- R10: A single-bit event with no multi-bit event in the same cycle drives `scrub_req` high for one cycle after the edge, with `scrub_addr` equal to the event address. This happens whether or not the event is logged, but only if bit 31 was 0 before that edge.
- R11: A write in the same cycle as an event, while an error is held, clears status bits as written but does not log that event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sbe_evt | input | 1 | Decoder strobe: single-bit error corrected on this read |
| mbe_evt | input | 1 | Decoder strobe: uncorrectable multi-bit error on this read |
| evt_addr | input | 32 | Physical address of the read |
| evt_syndrome | input | 8 | Syndrome of the read |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 32 | Status word write data |
| status | output | 32 | Current status word |
| sbe_irq | output | 1 | Interrupt pulse on a logged single-bit error |
| mbe_berr | output | 1 | Bus-error pulse on a logged multi-bit error |
| scrub_req | output | 1 | Scrub write-back request pulse |
| scrub_addr | output | 32 | Address to scrub, valid with `scrub_req` |

## Verification
The assertions check four things on every cycle:
- At most one status bit is ever set.
- The address and syndrome fields stay frozen while an error is held.
- A full acknowledge empties the status.
- A pulse never appears without its status bit, and a scrub request never follows a set disable bit.

Several outcomes can only be shown by the bench's scenarios, against a model of the status word:
- the exact captured field values;
- which kind wins when both events arrive in the same cycle;
- a write racing an event;
- the ignored read-only write bits;
- that pulses are suppressed when their enables are low.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    localparam int ADDR_W        = 32;
    localparam int SYN_W         = 8;
    localparam int REG_W         = 32;

    localparam int SBE_BIT       = 0;
    localparam int MBE_BIT       = 1;
    localparam int IRQ_EN_BIT    = 2;
    localparam int BERR_EN_BIT   = 3;
    localparam int SYN_LO        = 4;
    localparam int SYN_HI        = SYN_LO + SYN_W - 1;
    localparam int FLD_LO        = SYN_HI + 1;
    localparam int SCRUB_DIS_BIT = REG_W - 1;
    localparam int FLD_HI        = SCRUB_DIS_BIT - 1;
    localparam int KEEP_W        = FLD_HI - FLD_LO + 1;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_SBE  = 2'd1,
        EV_MBE  = 2'd2
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e              kind;
        logic [KEEP_W-1:0]     addr_hi;
        logic [SYN_W-1:0]      syn;
    } ev_rec_t;

    typedef struct packed {
        logic scrub_dis;
        logic berr_en;
        logic irq_en;
    } ctrl_t;

    function automatic ev_kind_e classify(input logic sbe, input logic mbe);
        if (mbe)      return EV_MBE;
        else if (sbe) return EV_SBE;
        else          return EV_NONE;
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.scrub_dis = w[SCRUB_DIS_BIT];
        c.berr_en   = w[BERR_EN_BIT];
        c.irq_en    = w[IRQ_EN_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(
        input ctrl_t             c,
        input logic [1:0]        st,
        input logic [KEEP_W-1:0] a,
        input logic [SYN_W-1:0]  s
    );
        logic [REG_W-1:0] r;
        r                    = '0;
        r[SCRUB_DIS_BIT]     = c.scrub_dis;
        r[FLD_HI:FLD_LO]     = a;
        r[SYN_HI:SYN_LO]     = s;
        r[BERR_EN_BIT]       = c.berr_en;
        r[IRQ_EN_BIT]        = c.irq_en;
        r[MBE_BIT]           = st[1];
        r[SBE_BIT]           = st[0];
        return r;
    endfunction

endpackage

// File: rtl/ecc_evt_select.sv
module ecc_evt_select
    import ecc_log_pkg::*;
(
    input  logic               sbe_evt,
    input  logic               mbe_evt,
    input  logic [ADDR_W-1:0]  evt_addr,
    input  logic [SYN_W-1:0]   evt_syndrome,
    output ev_rec_t            ev,
    output logic               scrub_hit
);
    always_comb begin
        ev.kind    = classify(sbe_evt, mbe_evt);
        ev.addr_hi = evt_addr[ADDR_W-1 -: KEEP_W];
        ev.syn     = evt_syndrome;
        scrub_hit  = sbe_evt && !mbe_evt;
    end
endmodule

// File: rtl/ecc_log_reg.sv
module ecc_log_reg
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ev_rec_t           ev,
    input  logic              wr_en,
    input  ctrl_t             wr_ctrl,
    input  logic [1:0]        wr_clr,
    output ctrl_t             ctrl_q,
    output logic [1:0]        st_q,
    output logic [KEEP_W-1:0] addr_q,
    output logic [SYN_W-1:0]  syn_q,
    output logic              cap_fire,
    output ev_kind_e          cap_kind
);
    logic       held;
    logic [1:0] st_n;

    always_comb begin
        held     = |st_q;
        cap_fire = !held && (ev.kind != EV_NONE);
        cap_kind = ev.kind;
        st_n     = st_q & ~(wr_en ? wr_clr : 2'b00);
        if (cap_fire)
            st_n = (ev.kind == EV_MBE) ? 2'b10 : 2'b01;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            st_q   <= '0;
            addr_q <= '0;
            syn_q  <= '0;
        end else begin
            if (wr_en)
                ctrl_q <= wr_ctrl;
            st_q <= st_n;
            if (cap_fire) begin
                addr_q <= ev.addr_hi;
                syn_q  <= ev.syn;
            end
        end
    end

    // Only one error kind is ever held.
    assert_one_status_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(st_q));

    // Fields do not move while an error is held.
    assert_hold_fields_R5: assert property (@(posedge clk) disable iff (rst)
        (|st_q) |=> ($stable(addr_q) && $stable(syn_q)));

    // Acknowledging every held bit empties the status.
    assert_w1c_empty_R6: assert property (@(posedge clk) disable iff (rst)
        ((|st_q) && wr_en && ((wr_clr & st_q) == st_q)) |=> (st_q == 2'b00));

    // A single-bit capture sets only the single-bit flag.
    assert_sbe_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (cap_fire && cap_kind == EV_SBE) |=> (st_q == 2'b01));

    // A multi-bit capture sets only the multi-bit flag.
    assert_mbe_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (cap_fire && cap_kind == EV_MBE) |=> (st_q == 2'b10));
endmodule

// File: rtl/ecc_log_notify.sv
module ecc_log_notify
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_fire,
    input  ev_kind_e          cap_kind,
    input  ctrl_t             ctrl,
    input  logic              scrub_hit,
    input  logic [ADDR_W-1:0] evt_addr,
    output logic              sbe_irq,
    output logic              mbe_berr,
    output logic              scrub_req,
    output logic [ADDR_W-1:0] scrub_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sbe_irq    <= 1'b0;
            mbe_berr   <= 1'b0;
            scrub_req  <= 1'b0;
            scrub_addr <= '0;
        end else begin
            sbe_irq   <= cap_fire && (cap_kind == EV_SBE) && ctrl.irq_en;
            mbe_berr  <= cap_fire && (cap_kind == EV_MBE) && ctrl.berr_en;
            scrub_req <= scrub_hit && !ctrl.scrub_dis;
            if (scrub_hit)
                scrub_addr <= evt_addr;
        end
    end

    // The two notification pulses never coincide.
    assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(sbe_irq && mbe_berr));

    // An interrupt pulse lasts one cycle, since the flag blocks re-capture.
    assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
        sbe_irq |=> !sbe_irq);

    // A bus-error pulse lasts one cycle.
    assert_berr_single_R9: assert property (@(posedge clk) disable iff (rst)
        mbe_berr |=> !mbe_berr);
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sbe_evt,
    input  logic              mbe_evt,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [SYN_W-1:0]  evt_syndrome,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  status,
    output logic              sbe_irq,
    output logic              mbe_berr,
    output logic              scrub_req,
    output logic [ADDR_W-1:0] scrub_addr
);
    ev_rec_t           ev;
    logic              scrub_hit;
    ctrl_t             ctrl_q;
    logic [1:0]        st_q;
    logic [KEEP_W-1:0] addr_q;
    logic [SYN_W-1:0]  syn_q;
    logic              cap_fire;
    ev_kind_e          cap_kind;
    ctrl_t             wr_ctrl;
    logic [1:0]        wr_clr;
    logic              unused_wr_bits;

    assign wr_ctrl        = ctrl_from_word(wr_data);
    assign wr_clr         = {wr_data[MBE_BIT], wr_data[SBE_BIT]};
    assign unused_wr_bits = ^wr_data[FLD_HI:SYN_LO];

    ecc_evt_select i_select (
        .sbe_evt      (sbe_evt),
        .mbe_evt      (mbe_evt),
        .evt_addr     (evt_addr),
        .evt_syndrome (evt_syndrome),
        .ev           (ev),
        .scrub_hit    (scrub_hit)
    );

    ecc_log_reg i_reg (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .wr_en    (wr_en),
        .wr_ctrl  (wr_ctrl),
        .wr_clr   (wr_clr),
        .ctrl_q   (ctrl_q),
        .st_q     (st_q),
        .addr_q   (addr_q),
        .syn_q    (syn_q),
        .cap_fire (cap_fire),
        .cap_kind (cap_kind)
    );

    ecc_log_notify i_notify (
        .clk        (clk),
        .rst        (rst),
        .cap_fire   (cap_fire),
        .cap_kind   (cap_kind),
        .ctrl       (ctrl_q),
        .scrub_hit  (scrub_hit),
        .evt_addr   (evt_addr),
        .sbe_irq    (sbe_irq),
        .mbe_berr   (mbe_berr),
        .scrub_req  (scrub_req),
        .scrub_addr (scrub_addr)
    );

    assign status = pack_status(ctrl_q, st_q, addr_q, syn_q);

    // A simultaneous pair from an empty log lands as multi-bit.
    assert_mbe_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (!(|status[1:0]) && sbe_evt && mbe_evt) |=> (status[1:0] == 2'b10));

    // An interrupt pulse always comes with the single-bit flag.
    assert_irq_flag_R8: assert property (@(posedge clk) disable iff (rst)
        sbe_irq |-> status[SBE_BIT]);

    // A bus-error pulse always comes with the multi-bit flag.
    assert_berr_flag_R9: assert property (@(posedge clk) disable iff (rst)
        mbe_berr |-> status[MBE_BIT]);

    // No scrub request follows an edge at which scrubbing was disabled.
    assert_scrub_gate_R10: assert property (@(posedge clk) disable iff (rst)
        scrub_req |-> !$past(status[SCRUB_DIS_BIT]));
endmodule

// File: tb/test_ecc_err_logger.sv
`timescale 1ns/1ps
module test_ecc_err_logger;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sbe_evt = 1'b0;
    logic        mbe_evt = 1'b0;
    logic [31:0] evt_addr = '0;
    logic [7:0]  evt_syndrome = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] status;
    logic        sbe_irq, mbe_berr, scrub_req;
    logic [31:0] scrub_addr;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] mdl = '0;

    always #2.5 clk = ~clk;

    ecc_err_logger i_ecc_err_logger (
        .clk(clk), .rst(rst), .sbe_evt(sbe_evt), .mbe_evt(mbe_evt),
        .evt_addr(evt_addr), .evt_syndrome(evt_syndrome),
        .wr_en(wr_en), .wr_data(wr_data), .status(status),
        .sbe_irq(sbe_irq), .mbe_berr(mbe_berr),
        .scrub_req(scrub_req), .scrub_addr(scrub_addr)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of the next status word from the requirements.
    function automatic logic [31:0] next_word(input logic [31:0] r, input logic s, input logic m,
                                              input logic [31:0] a, input logic [7:0] y,
                                              input logic we, input logic [31:0] wd);
        logic [31:0] n;
        logic held;
        held = r[0] | r[1];
        n = r;
        if (we) begin
            n[31]  = wd[31];
            n[3:2] = wd[3:2];
            n[1:0] = r[1:0] & ~wd[1:0];
        end
        if (!held && (s || m)) begin
            n[30:12] = a[31:13];
            n[11:4]  = y;
            n[1:0]   = m ? 2'b10 : 2'b01;
        end
        return n;
    endfunction

    task automatic apply(input logic s, input logic m, input logic [31:0] a, input logic [7:0] y,
                         input logic we, input logic [31:0] wd, input string req);
        logic held;
        logic e_irq, e_berr, e_scrub;
        logic [31:0] e_word;
        held    = mdl[0] | mdl[1];
        e_irq   = !held && s && !m && mdl[2];
        e_berr  = !held && m && mdl[3];
        e_scrub = s && !m && !mdl[31];
        e_word  = next_word(mdl, s, m, a, y, we, wd);
        sbe_evt = s; mbe_evt = m; evt_addr = a; evt_syndrome = y;
        wr_en = we; wr_data = wd;
        @(posedge clk);
        @(negedge clk);
        sbe_evt = 1'b0; mbe_evt = 1'b0; wr_en = 1'b0;
        check(status, e_word, req);
        check({31'b0, sbe_irq}, {31'b0, e_irq}, "R8 sbe_irq");
        check({31'b0, mbe_berr}, {31'b0, e_berr}, "R9 mbe_berr");
        check({31'b0, scrub_req}, {31'b0, e_scrub}, "R10 scrub_req");
        if (e_scrub) check(scrub_addr, a, "R10 scrub_addr");
        mdl = e_word;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_vec++; n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(status, 32'h0, "R1 status");
        check({29'b0, sbe_irq, mbe_berr, scrub_req}, 32'h0, "R1 pulses");

        // R7: control bits load, read-only field bits ignored
        apply(0, 0, 32'h0, 8'h00, 1, 32'h7FFF_FFFC, "R7");
        // R2: single-bit capture
        apply(1, 0, 32'hDEAD_B123, 8'h5A, 0, 32'h0, "R2");
        // R5: multi-bit while held is dropped (no berr)
        apply(0, 1, 32'h1234_5678, 8'hC3, 0, 32'h0, "R5");
        apply(1, 0, 32'h0F0F_0F0F, 8'h11, 0, 32'h0, "R5");
        // R11: clear races an event while held
        apply(1, 0, 32'hAAAA_AAAA, 8'h77, 1, 32'h0000_000D, "R11");
        // R4: simultaneous events from empty log
        apply(1, 1, 32'hCAFE_F00D, 8'h99, 0, 32'h0, "R4");
        // R6: writing zero to status bits leaves them
        apply(0, 0, 32'h0, 8'h00, 1, 32'h0000_000C, "R6");
        // R6: writing one to wrong bit leaves held bit
        apply(0, 0, 32'h0, 8'h00, 1, 32'h0000_000D, "R6");
        // R6: clear the multi-bit flag
        apply(0, 0, 32'h0, 8'h00, 1, 32'h0000_000E, "R6");
        // R3: fresh multi-bit capture after clear
        apply(0, 1, 32'h8000_2000, 8'hFE, 0, 32'h0, "R3");
        // R10: disable scrub, keep irq only
        apply(0, 0, 32'h0, 8'h00, 1, 32'h8000_0006, "R10");
        apply(1, 0, 32'h0000_4000, 8'h01, 0, 32'h0, "R10");
        // R8: interrupt enable low suppresses pulse
        apply(0, 0, 32'h0, 8'h00, 1, 32'h0000_0001, "R8");
        apply(1, 0, 32'hFFFF_E000, 8'hFF, 0, 32'h0, "R8");
        // R9: bus-error enable low suppresses pulse
        apply(0, 0, 32'h0, 8'h00, 1, 32'h0000_0001, "R9");
        apply(0, 1, 32'h0000_0000, 8'h00, 0, 32'h0, "R9");
        apply(0, 0, 32'h0, 8'h00, 1, 32'h0000_000E, "R9");

        // Random mix, all requirements through the model
        for (int i = 0; i < 600; i++) begin
            logic s, m, we;
            logic [31:0] wd;
            s  = ($urandom % 4) == 0;
            m  = ($urandom % 8) == 0;
            we = ($urandom % 5) == 0;
            wd = $urandom;
            apply(s, m, $urandom, 8'($urandom), we, wd, "R5 random");
        end
        finish_run();
    end
endmodule